// File: doc/BRIEF.md
# Four-Channel Output Compare Unit

This block drives four output pins from a single 16-bit timer count that arrives as a plain input. Each channel holds its own 16-bit compare value and its own action. When the count first equals that channel's compare value, the channel sets its pin, clears it, or toggles it. The counter itself, prescaling, reload and pin multiplexing all live outside the block.

A CPU loads the block through a byte-wide write port. A compare value arrives as two bytes, and the value becomes active only when its upper half is written, so a half-updated value can never produce a match. The same port sets a global enable, a per-channel level bit and a 2-bit action field per channel.

Action 0 pins the output to the channel's level bit, and matches are ignored while that action is selected. A channel can therefore start at 1 or be overridden at any time. When the channel is given a normal action again, the pin keeps the forced level until a later match changes it.

Top module: `cmpout_unit`

## Requirements
- R1: While synchronous reset is high, and after it is released with no writes, every pin is 0. All compare values reset to 0, every action field resets to 0, every level bit resets to 0, and the enable resets to 0.
- R2: A write to address 2n (n = 0..3) stores the low byte of channel n in a holding register without changing the active compare value. A write to address 2n+1 makes {written byte, held low byte} the active value from the next cycle. A low-byte write alone never causes a match.
- R3: A match acts once, in the first cycle the count equals the compare value. A count that stays equal for several cycles triggers only one action. A fresh action needs the count to leave the value and return.
- R4: The action field of channel n is bits [2n+1:2n] of address 10. Value 1 drives the pin to 1 on a match.
- R5: Action value 2 drives the pin to 0 on a match.
- R6: Action value 3 inverts the pin on a match.
- R7: Bit 0 of address 8 is the global enable. While it is 0, matches change no pin, and pins with a non-zero action hold their level.
- R8: Action value 0 drives the pin to bit n of address 9 (the level bit) from the next clock onward, whatever the count and the enable. Matches are ignored while the action stays 0.
- R9: When a channel's action changes from 0 to a non-zero value, the pin keeps the forced level until a later match acts on it.
- R10: A pin changes at the clock edge that ends the cycle in which the count first equals the compare value. There is exactly one register stage between the match and the pin.
- R11: Channels act independently. Several channels matching the same count in the same cycle each apply their own action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_cnt_i | input | 16 | Shared timer count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| oc_pin_o | output | 4 | Compare output pins |

## Verification
A wrong internal state shows up quickly at the pins. A corrupted compare value or a mis-committed half write moves or suppresses the pin change at the expected match edge. A lost or stuck edge-detect bit causes a missing toggle or a repeated toggle while the count is held. A bad action or level bit gives the wrong pin value one clock after the match or the mode write. Because the bench compares all four pins every cycle, any such fault is reported within one clock of the edge where it first becomes visible.

// File: rtl/cmpout_pkg.sv
`timescale 1ns/1ps
package cmpout_pkg;

    localparam int OC_NCH = 4;
    localparam int OC_DW  = 8;
    localparam int OC_AW  = 4;
    localparam int OC_CW  = 2 * OC_DW;

    // register addresses above the compare byte pairs
    localparam logic [3:0] ADDR_CTRL = 4'd8;
    localparam logic [3:0] ADDR_LVL  = 4'd9;
    localparam logic [3:0] ADDR_ACT  = 4'd10;

    typedef enum logic [1:0] {
        ACT_FORCE  = 2'd0,
        ACT_SET    = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_TOGGLE = 2'd3
    } oc_act_e;

    // next pin level for one channel given its action and a qualified match
    function automatic logic next_level(oc_act_e act, logic cur, logic lvl, logic fire);
        logic nxt;
        nxt = cur;
        unique case (act)
            ACT_FORCE:  nxt = lvl;
            ACT_SET:    nxt = fire ? 1'b1 : cur;
            ACT_CLEAR:  nxt = fire ? 1'b0 : cur;
            ACT_TOGGLE: nxt = fire ? ~cur : cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/cmpout_regs.sv
`timescale 1ns/1ps
module cmpout_regs
    import cmpout_pkg::*;
#(
    parameter int NCH = OC_NCH,
    parameter int DW  = OC_DW,
    parameter int AW  = OC_AW,
    localparam int CW = 2 * DW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we_i,
    input  logic [AW-1:0]             addr_i,
    input  logic [DW-1:0]             data_i,
    output logic [NCH-1:0][CW-1:0]    cmp_o,
    output oc_act_e [NCH-1:0]         act_o,
    output logic [NCH-1:0]            lvl_o,
    output logic                      en_o
);

    logic [NCH-1:0][DW-1:0] stage_q;
    logic [NCH-1:0][CW-1:0] cmp_q;
    logic [2*NCH-1:0]       act_q;
    logic [NCH-1:0]         lvl_q;
    logic                   en_q;

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        localparam logic [AW-1:0] LO_ADDR = AW'(2 * g);
        localparam logic [AW-1:0] HI_ADDR = AW'(2 * g + 1);

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= '0;
                cmp_q[g]   <= '0;
            end else if (we_i && addr_i == LO_ADDR) begin
                stage_q[g] <= data_i;
            end else if (we_i && addr_i == HI_ADDR) begin
                cmp_q[g]   <= {data_i, stage_q[g]};
            end
        end

        assign act_o[g] = oc_act_e'(act_q[2*g +: 2]);

        // R2
        lo_write_holds_chk: assert property (@(posedge clk) disable iff (rst)
            (we_i && addr_i == LO_ADDR) |=> $stable(cmp_q[g]));

        // R2
        hi_write_commits_chk: assert property (@(posedge clk) disable iff (rst)
            (we_i && addr_i == HI_ADDR) |=> cmp_q[g] == {$past(data_i), $past(stage_q[g])});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            lvl_q <= '0;
            en_q  <= 1'b0;
        end else if (we_i) begin
            if (addr_i == AW'(ADDR_CTRL)) en_q  <= data_i[0];
            if (addr_i == AW'(ADDR_LVL))  lvl_q <= data_i[NCH-1:0];
            if (addr_i == AW'(ADDR_ACT))  act_q <= data_i[2*NCH-1:0];
        end
    end

    assign cmp_o = cmp_q;
    assign lvl_o = lvl_q;
    assign en_o  = en_q;

endmodule

// File: rtl/cmpout_match.sv
`timescale 1ns/1ps
module cmpout_match
    import cmpout_pkg::*;
#(
    parameter int NCH = OC_NCH,
    parameter int CW  = OC_CW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CW-1:0]          tmr_i,
    input  logic [NCH-1:0][CW-1:0] cmp_i,
    output logic [NCH-1:0]         hit_o
);

    logic [NCH-1:0] eq;
    logic [NCH-1:0] eq_q;

    for (genvar g = 0; g < NCH; g++) begin : g_det
        assign eq[g]    = (tmr_i == cmp_i[g]);
        assign hit_o[g] = eq[g] & ~eq_q[g];

        always_ff @(posedge clk) begin
            if (rst) eq_q[g] <= 1'b0;
            else     eq_q[g] <= eq[g];
        end

        // R3
        single_hit_chk: assert property (@(posedge clk) disable iff (rst)
            hit_o[g] |=> !hit_o[g]);
    end

endmodule

// File: rtl/cmpout_action.sv
`timescale 1ns/1ps
module cmpout_action
    import cmpout_pkg::*;
#(
    parameter int NCH = OC_NCH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       hit_i,
    input  logic                 en_i,
    input  oc_act_e [NCH-1:0]    act_i,
    input  logic [NCH-1:0]       lvl_i,
    output logic [NCH-1:0]       pin_o
);

    logic [NCH-1:0] pin_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) pin_q[g] <= 1'b0;
            else     pin_q[g] <= next_level(act_i[g], pin_q[g], lvl_i[g], hit_i[g] & en_i);
        end

        // R4
        set_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
            (hit_i[g] && en_i && act_i[g] == ACT_SET) |=> pin_q[g]);

        // R5
        clear_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
            (hit_i[g] && en_i && act_i[g] == ACT_CLEAR) |=> !pin_q[g]);

        // R6
        toggle_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
            (hit_i[g] && en_i && act_i[g] == ACT_TOGGLE) |=> pin_q[g] != $past(pin_q[g]));

        // R7
        disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!en_i && act_i[g] != ACT_FORCE) |=> $stable(pin_q[g]));

        // R8
        forced_level_chk: assert property (@(posedge clk) disable iff (rst)
            (act_i[g] == ACT_FORCE) |=> pin_q[g] == $past(lvl_i[g]));

        // R9
        hold_without_hit_chk: assert property (@(posedge clk) disable iff (rst)
            (act_i[g] != ACT_FORCE && !hit_i[g]) |=> $stable(pin_q[g]));
    end

    assign pin_o = pin_q;

endmodule

// File: rtl/cmpout_unit.sv
`timescale 1ns/1ps
module cmpout_unit
    import cmpout_pkg::*;
#(
    parameter int NCH = OC_NCH,
    parameter int DW  = OC_DW,
    parameter int AW  = OC_AW,
    localparam int CW = 2 * DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CW-1:0]  tmr_cnt_i,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  wr_addr_i,
    input  logic [DW-1:0]  wr_data_i,
    output logic [NCH-1:0] oc_pin_o
);

    logic [NCH-1:0][CW-1:0] cmp;
    oc_act_e [NCH-1:0]      act;
    logic [NCH-1:0]         lvl;
    logic                   en;
    logic [NCH-1:0]         hit;

    cmpout_regs #(.NCH(NCH), .DW(DW), .AW(AW)) regs_i (
        .clk    (clk),
        .rst    (rst),
        .we_i   (wr_en_i),
        .addr_i (wr_addr_i),
        .data_i (wr_data_i),
        .cmp_o  (cmp),
        .act_o  (act),
        .lvl_o  (lvl),
        .en_o   (en)
    );

    cmpout_match #(.NCH(NCH), .CW(CW)) match_i (
        .clk   (clk),
        .rst   (rst),
        .tmr_i (tmr_cnt_i),
        .cmp_i (cmp),
        .hit_o (hit)
    );

    cmpout_action #(.NCH(NCH)) action_i (
        .clk   (clk),
        .rst   (rst),
        .hit_i (hit),
        .en_i  (en),
        .act_i (act),
        .lvl_i (lvl),
        .pin_o (oc_pin_o)
    );

    // R1
    reset_clears_pins_chk: assert property (@(posedge clk)
        rst |=> oc_pin_o == '0);

endmodule

// File: tb/cmpout_unit_tb_top.sv
`timescale 1ns/1ps
module cmpout_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] tmr;
    logic        we;
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic [3:0]  pins;

    cmpout_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .tmr_cnt_i (tmr),
        .wr_en_i   (we),
        .wr_addr_i (addr),
        .wr_data_i (wdata),
        .oc_pin_o  (pins)
    );

    always #4 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    started = 0;
    string phase = "R1";

    // behavioural reference state
    int m_cmp   [4];
    int m_stage [4];
    int m_eqp   [4];
    int m_pin   [4];
    int m_act   [4];
    int m_lvl   [4];
    int m_en;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 4; c++) begin
                m_cmp[c] = 0; m_stage[c] = 0; m_eqp[c] = 0;
                m_pin[c] = 0; m_act[c] = 0; m_lvl[c] = 0;
            end
            m_en = 0;
        end else begin
            for (int c = 0; c < 4; c++) begin
                int eq;
                int hit;
                eq  = (int'(tmr) == m_cmp[c]) ? 1 : 0;
                hit = (eq == 1 && m_eqp[c] == 0) ? 1 : 0;
                m_eqp[c] = eq;
                if (m_act[c] == 0) m_pin[c] = m_lvl[c];
                else if (hit == 1 && m_en == 1) begin
                    if (m_act[c] == 1) m_pin[c] = 1;
                    else if (m_act[c] == 2) m_pin[c] = 0;
                    else m_pin[c] = 1 - m_pin[c];
                end
            end
            if (we) begin
                if (addr < 8) begin
                    if (addr % 2 == 0) m_stage[addr / 2] = int'(wdata);
                    else m_cmp[addr / 2] = int'(wdata) * 256 + m_stage[addr / 2];
                end else if (addr == 8) m_en = int'(wdata[0]);
                else if (addr == 9) begin
                    for (int c = 0; c < 4; c++) m_lvl[c] = int'(wdata[c]);
                end else if (addr == 10) begin
                    for (int c = 0; c < 4; c++) m_act[c] = int'(wdata[2*c +: 2]);
                end
            end
        end
        started = 1;
    end

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            logic [3:0] exp_v;
            for (int c = 0; c < 4; c++) exp_v[c] = (m_pin[c] != 0);
            n_cmp++;
            if (pins !== exp_v) begin
                n_bad++;
                $display("FAIL %s: pins actual %b expected %b (tmr %h)", phase, pins, exp_v, tmr);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 20000) begin
            n_bad++;
            $display("FAIL watchdog: cycles actual %0d expected below %0d", cycles, 20000);
            summary_and_end();
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic step(input logic [15:0] t);
        tmr = t;
        @(negedge clk);
    endtask

    task automatic sweep(input logic [15:0] first, input int n);
        for (int i = 0; i < n; i++) step(first + 16'(i));
    endtask

    task automatic hold(input logic [15:0] t, input int n);
        for (int i = 0; i < n; i++) step(t);
    endtask

    initial begin
        rst = 1'b1; we = 1'b0; addr = '0; wdata = '0; tmr = 16'h0100;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        phase = "R1";
        hold(16'h0100, 3);

        // forced levels apply with the enable still clear
        phase = "R8";
        wr(4'd9, 8'h0A);
        hold(16'h0100, 2);
        wr(4'd8, 8'h01);
        hold(16'h0000, 3);
        sweep(16'h00FE, 4);

        // ch0 set, ch1 clear, ch2 toggle, ch3 set; pins keep forced levels
        phase = "R9";
        wr(4'd10, 8'h79);
        hold(16'h0200, 4);

        // low byte only: staged, not active
        phase = "R2";
        wr(4'd0, 8'h34);
        sweep(16'h0030, 9);
        sweep(16'h1230, 9);
        wr(4'd1, 8'h12);

        phase = "R4";
        sweep(16'h1230, 9);

        phase = "R10";
        hold(16'h1233, 2);
        step(16'h1234);
        hold(16'h1235, 2);

        phase = "R5";
        wr(4'd2, 8'h00);
        wr(4'd3, 8'h20);
        sweep(16'h1FFE, 5);

        phase = "R3";
        wr(4'd4, 8'h00);
        wr(4'd5, 8'h30);
        hold(16'h2FFF, 2);
        hold(16'h3000, 6);

        phase = "R6";
        step(16'h3001);
        step(16'h3000);
        step(16'h3001);
        step(16'h3000);
        hold(16'h3002, 2);

        // ch0 clear, ch1 clear, ch2 toggle, ch3 clear, three share one value
        phase = "R11";
        wr(4'd10, 8'hBA);
        wr(4'd0, 8'h00); wr(4'd1, 8'h40);
        wr(4'd4, 8'h00); wr(4'd5, 8'h40);
        wr(4'd6, 8'h00); wr(4'd7, 8'h40);
        hold(16'h3FFF, 2);
        hold(16'h4000, 3);
        step(16'h4001);

        phase = "R7";
        wr(4'd8, 8'h00);
        step(16'h4000);
        step(16'h4001);
        step(16'h4000);
        hold(16'h4001, 2);
        wr(4'd8, 8'h01);
        step(16'h4000);
        step(16'h4001);

        // force ch3 high, then hand it back to toggle
        phase = "R8";
        wr(4'd9, 8'h08);
        wr(4'd10, 8'h3A);
        hold(16'h4001, 2);
        step(16'h4000);
        step(16'h4001);

        phase = "R9";
        wr(4'd10, 8'hFA);
        hold(16'h5000, 5);
        step(16'h4000);
        hold(16'h4002, 3);

        phase = "R1";
        rst = 1'b1;
        hold(16'h4000, 2);
        rst = 1'b0;
        hold(16'h0000, 3);

        summary_and_end();
    end

endmodule